// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a 16-bit down-counting supervisor for a processor subsystem. It counts slow ticks, thinned out by a selectable divider. Software services it by writing a clear register before the count runs out. If software fails to do so, the block raises either a one-cycle reset request for the reset controller or a held interrupt request, depending on a mode bit.

The timer is already running when reset is released. Early boot code may stop it, change its divider, mode and reload value, and then start it again. Starting it through the control register also freezes the control and reload registers until the next reset. The slow clock enters as a one-cycle tick enable that is synchronous to the bus clock. Registers are reached over a small word-addressed bus with registered read data.

Top module: `wdog_lockable`

## Requirements
- R1: After reset the reload register reads 0x1000, the count reads 0x1000, control reads 0x00E9 (start bit 5 = 1, divider field bits [3:2] = 2'b10, mode bit 1 = 0 for reset mode), status reads 0, and the lock is clear.
- R2: Word offsets are 0 reload, 1 current count, 2 control, 3 clear (writes only, reads 0) and 4 status. Read data appears on `bus_rdata` one clock after the address is presented with `bus_sel` high and `bus_wr` low.
- R3: The divider field picks how many ticks make one count step: 2'b00 gives 1, 2'b01 gives 16, 2'b10 gives 256 and 2'b11 gives 4096. Fewer ticks than that leave the count unchanged.
- R4: A count step taken while the count is 1 or less is a timeout. On a timeout the count reloads from the reload register and keeps running, so a timeout follows reload × ratio ticks after a reload.
- R5: In reset mode (bit 1 = 0), a timeout drives `wd_rst_req` high for exactly one cycle, and `wd_irq` stays low.
- R6: In interrupt mode (bit 1 = 1), a timeout sets `wd_irq`, which stays high until a clear write. `wd_rst_req` stays low.
- R7: In interrupt mode, status bit 0 is high for exactly two clock cycles per timeout.
- R8: A write of any value to the clear register reloads the count from the reload register, zeroes the divider and drops `wd_irq`.
- R9: A control write that the block accepts with bit 5 = 1 sets the lock, shown as status bit 4. While the lock is set, writes to reload and control have no effect and the timer keeps running. Only reset clears the lock.
- R10: While the lock is clear, reload writes take effect. A control write with bit 5 = 0 stops counting, so the count holds while ticks arrive.
- R11: An accepted control write reloads the count from the reload register and zeroes the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| lf_tick | input | 1 | One-cycle pulse per slow-clock period |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| wd_rst_req | output | 1 | One-cycle reset request on timeout in reset mode |
| wd_irq | output | 1 | Held interrupt request in interrupt mode |

## Verification
The assertions assume that `lf_tick` is a clean single-cycle enable in the bus clock domain. They also assume that a bus access is one cycle long and that the address is stable while it lasts. The bench drives every input at the falling edge and raises `bus_sel` for one cycle per access, so it stays within these assumptions. The assertions also assume that a clear write never arrives in the cycle of a timeout. The bench avoids this by stopping ticks before it services the timer.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W    = 3;
  localparam int EN_BIT    = 5;
  localparam int MODE_BIT  = 1;
  localparam int SEL_LO    = 2;
  localparam int SEL_W     = 2;
  localparam int LOCK_SBIT = 4;
  localparam int PULS_SBIT = 0;

  typedef enum logic [ADDR_W-1:0] {
    A_LOAD  = 3'd0,
    A_VALUE = 3'd1,
    A_CTRL  = 3'd2,
    A_CLEAR = 3'd3,
    A_STAT  = 3'd4
  } wd_addr_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int SEL_W   = 2,
  parameter int DIV_LOG = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             step
);
  localparam int N_SEL = 1 << SEL_W;
  localparam int PRE_W = DIV_LOG * (N_SEL - 1);

  logic [PRE_W-1:0] lim [N_SEL];
  logic [PRE_W-1:0] pcnt;
  logic             hit;

  for (genvar g = 0; g < N_SEL; g++) begin : g_lim
    assign lim[g] = PRE_W'((64'd1 << (DIV_LOG * g)) - 64'd1);
  end

  assign hit  = (pcnt == lim[sel]);
  assign step = en & tick & hit;

  always_ff @(posedge clk) begin
    if (rst || clr || !en) pcnt <= '0;
    else if (tick)         pcnt <= hit ? '0 : pcnt + 1'b1;
  end

  // R10: a stopped timer keeps its divider at zero
  a_r10_idle_div: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pcnt == '0));
  // R8: clear restarts division
  a_r8_div_restart: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pcnt == '0));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int              CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_VAL = 16'h1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic at_end;
  assign at_end = (count <= CNT_W'(1));
  assign expire = step & ~reload & at_end;

  always_ff @(posedge clk) begin
    if (rst)                 count <= RST_VAL;
    else if (reload)         count <= load_val;
    else if (step && at_end) count <= load_val;
    else if (step)           count <= count - 1'b1;
  end

  // R4: each step above one takes exactly one off the count
  a_r4_decrement: assert property (@(posedge clk) disable iff (rst)
    (step && !reload && !at_end) |=> (count == $past(count) - CNT_W'(1)));
  // R10: no step and no reload leaves the count alone
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !reload) |=> $stable(count));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs #(
  parameter int                DATA_W   = 16,
  parameter int                EN_BIT   = 5,
  parameter logic [DATA_W-1:0] RST_LOAD = 16'h1000,
  parameter logic [DATA_W-1:0] RST_CTRL = 16'h00E9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_load,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] load_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              locked,
  output logic              ctrl_taken
);
  logic load_taken;
  assign ctrl_taken = wr_ctrl & ~locked;
  assign load_taken = wr_load & ~locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= RST_LOAD;
      ctrl_q <= RST_CTRL;
      locked <= 1'b0;
    end else begin
      if (load_taken) load_q <= wdata;
      if (ctrl_taken) begin
        ctrl_q <= wdata;
        if (wdata[EN_BIT]) locked <= 1'b1;
      end
    end
  end

  // R9: lock is sticky and freezes both registers
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);
  a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
    locked |=> ($stable(load_q) && $stable(ctrl_q)));
endmodule

// File: rtl/wdog_lockable.sv
module wdog_lockable
  import wdog_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter int                DIV_LOG  = 4,
  parameter logic [DATA_W-1:0] RST_LOAD = 16'h1000,
  parameter logic [DATA_W-1:0] RST_CTRL = 16'h00E9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lf_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wd_rst_req,
  output logic              wd_irq
);
  logic              wr, wr_load, wr_ctrl, wr_clr;
  logic [DATA_W-1:0] load_q, ctrl_q, count, stat;
  logic              locked, ctrl_taken, step, expire, reload;
  logic              en, irq_mode;
  logic [1:0]        pulse_cnt;
  logic              pulse;

  assign wr      = bus_sel & bus_wr;
  assign wr_load = wr & (bus_addr == A_LOAD);
  assign wr_ctrl = wr & (bus_addr == A_CTRL);
  assign wr_clr  = wr & (bus_addr == A_CLEAR);

  wdog_regs #(.DATA_W(DATA_W), .EN_BIT(EN_BIT), .RST_LOAD(RST_LOAD), .RST_CTRL(RST_CTRL)) u_regs (
    .clk(clk), .rst(rst), .wr_load(wr_load), .wr_ctrl(wr_ctrl), .wdata(bus_wdata),
    .load_q(load_q), .ctrl_q(ctrl_q), .locked(locked), .ctrl_taken(ctrl_taken));

  assign en       = ctrl_q[EN_BIT];
  assign irq_mode = ctrl_q[MODE_BIT];
  assign reload   = ctrl_taken | wr_clr;

  wdog_prescaler #(.SEL_W(SEL_W), .DIV_LOG(DIV_LOG)) u_pre (
    .clk(clk), .rst(rst), .en(en), .clr(reload), .tick(lf_tick),
    .sel(ctrl_q[SEL_LO +: SEL_W]), .step(step));

  wdog_counter #(.CNT_W(DATA_W), .RST_VAL(RST_LOAD)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .reload(reload), .load_val(load_q),
    .count(count), .expire(expire));

  assign pulse = (pulse_cnt != 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_rst_req <= 1'b0;
      wd_irq     <= 1'b0;
      pulse_cnt  <= 2'd0;
    end else begin
      wd_rst_req <= expire & ~irq_mode;
      if (expire && irq_mode) wd_irq <= 1'b1;
      else if (wr_clr)        wd_irq <= 1'b0;
      if (expire && irq_mode) pulse_cnt <= 2'd2;
      else if (pulse)         pulse_cnt <= pulse_cnt - 2'd1;
    end
  end

  always_comb begin
    stat            = '0;
    stat[LOCK_SBIT] = locked;
    stat[PULS_SBIT] = pulse;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        A_LOAD:  bus_rdata <= load_q;
        A_VALUE: bus_rdata <= count;
        A_CTRL:  bus_rdata <= ctrl_q;
        A_STAT:  bus_rdata <= stat;
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R5: reset-mode timeout requests reset next cycle, one cycle only
  a_r5_rst_pulse: assert property (@(posedge clk) disable iff (rst)
    (expire && !irq_mode) |=> wd_rst_req);
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (wd_rst_req && !expire) |=> !wd_rst_req);
  // R6: an interrupt never rises together with a reset request
  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_irq) |-> !wd_rst_req);
  // R7: status pulse lasts at least two cycles
  a_r7_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |=> pulse);
  // R8: clear drops the interrupt
  a_r8_clear_irq: assert property (@(posedge clk) disable iff (rst)
    (wr_clr && !expire) |=> !wd_irq);
endmodule

// File: tb/wdog_lockable_bench.sv
module wdog_lockable_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lf_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        wd_rst_req, wd_irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [15:0] rd;

  localparam logic [2:0] OFF_LOAD = 3'd0, OFF_VAL = 3'd1, OFF_CTRL = 3'd2,
                         OFF_CLR = 3'd3, OFF_STAT = 3'd4;

  // vector: {divider select[18:17], interrupt mode[16], reload[15:0]}
  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    {2'd0, 1'b0, 16'd5},
    {2'd1, 1'b1, 16'd3},
    {2'd2, 1'b0, 16'd2},
    {2'd3, 1'b1, 16'd2},
    {2'd0, 1'b1, 16'd1},
    {2'd1, 1'b0, 16'd1}
  };

  always #4 clk = ~clk;

  wdog_lockable u_wdog_lockable (
    .clk(clk), .rst(rst), .lf_tick(lf_tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_rst_req(wd_rst_req), .wd_irq(wd_irq));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; lf_tick = 1'b0; bus_sel = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); lf_tick = 1'b1;
    end
    @(negedge clk); lf_tick = 1'b0;
  endtask

  initial begin
    // ---- vector table: ratio and timeout per divider/mode ----
    for (int v = 0; v < NV; v++) begin
      logic [1:0]  sel;
      logic        md;
      logic [15:0] ld;
      int          n;
      int          exp_n;
      bit          other;
      sel = VEC[v][18:17]; md = VEC[v][16]; ld = VEC[v][15:0];
      exp_n = int'(ld) << (4 * sel);
      do_reset();
      wr_reg(OFF_LOAD, ld);
      wr_reg(OFF_CTRL, 16'h0020 | (16'(sel) << 2) | (16'(md) << 1));
      @(negedge clk); lf_tick = 1'b1;
      n = 0; other = 1'b0;
      while (n < 20000) begin
        @(posedge clk); #1;
        n++;
        if (md ? wd_rst_req : wd_irq) other = 1'b1;
        if (md ? wd_irq : wd_rst_req) break;
      end
      @(negedge clk); lf_tick = 1'b0;
      chk("R3/R4 ticks to timeout", n, exp_n);
      chk("R5/R6 other output quiet", other, 0);
      @(posedge clk); #1;
      if (md) chk("R6 irq held", wd_irq, 1);
      else    chk("R5 reset request one cycle", wd_rst_req, 0);
      if (!md) chk("R5 irq low in reset mode", wd_irq, 0);
      rd_reg(OFF_VAL, rd);
      chk("R4 reload after timeout", rd, ld);
      rd_reg(OFF_STAT, rd);
      chk("R9 lock status bit 4", rd[4], 1);
    end

    // ---- R1/R2 reset values ----
    do_reset();
    rd_reg(OFF_LOAD, rd); chk("R1 reload reset", rd, 16'h1000);
    rd_reg(OFF_VAL, rd);  chk("R1 count reset", rd, 16'h1000);
    rd_reg(OFF_CTRL, rd); chk("R1 control reset", rd, 16'h00E9);
    rd_reg(OFF_STAT, rd); chk("R1 status reset", rd, 16'h0000);
    rd_reg(OFF_CLR, rd);  chk("R2 clear reads zero", rd, 16'h0000);
    chk("R1 outputs idle", {wd_rst_req, wd_irq}, 0);

    // ---- R3 default divider 256, R8 clear zeroes divider ----
    ticks(255);
    rd_reg(OFF_VAL, rd); chk("R3 255 ticks no step", rd, 16'h1000);
    ticks(1);
    rd_reg(OFF_VAL, rd); chk("R3 256th tick steps", rd, 16'h0FFF);
    ticks(200);
    wr_reg(OFF_CLR, 16'h1234);
    rd_reg(OFF_VAL, rd); chk("R8 clear reloads", rd, 16'h1000);
    ticks(255);
    rd_reg(OFF_VAL, rd); chk("R8 divider zeroed by clear", rd, 16'h1000);
    ticks(1);
    rd_reg(OFF_VAL, rd); chk("R8 step after full ratio", rd, 16'h0FFF);

    // ---- R10 stop, edit, R11 restart ----
    wr_reg(OFF_CTRL, 16'h0000);
    rd_reg(OFF_STAT, rd); chk("R10 stop does not lock", rd[4], 0);
    rd_reg(OFF_VAL, rd); chk("R11 stop write reloads", rd, 16'h1000);
    ticks(300);
    rd_reg(OFF_VAL, rd); chk("R10 stopped count holds", rd, 16'h1000);
    wr_reg(OFF_LOAD, 16'h0007);
    rd_reg(OFF_LOAD, rd); chk("R10 reload write taken", rd, 16'h0007);
    ticks(3);
    wr_reg(OFF_CTRL, 16'h0022);
    rd_reg(OFF_VAL, rd); chk("R11 start write reloads", rd, 16'h0007);
    rd_reg(OFF_STAT, rd); chk("R9 locked after start", rd[4], 1);

    // ---- R9 locked writes ignored ----
    wr_reg(OFF_LOAD, 16'h0055);
    rd_reg(OFF_LOAD, rd); chk("R9 reload write ignored", rd, 16'h0007);
    wr_reg(OFF_CTRL, 16'h0000);
    rd_reg(OFF_CTRL, rd); chk("R9 control write ignored", rd, 16'h0022);
    ticks(3);
    rd_reg(OFF_VAL, rd); chk("R9 timer still runs", rd, 16'h0004);

    // ---- R7 status pulse width ----
    ticks(3);
    rd_reg(OFF_VAL, rd); chk("R4 count at one", rd, 16'h0001);
    begin
      int hi;
      hi = 0;
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = OFF_STAT; lf_tick = 1'b1;
      @(posedge clk); #1;
      if (bus_rdata[0]) hi++;
      @(negedge clk); lf_tick = 1'b0;
      for (int k = 0; k < 6; k++) begin
        @(posedge clk); #1;
        if (bus_rdata[0]) hi++;
      end
      @(negedge clk); bus_sel = 1'b0;
      chk("R7 status pulse cycles", hi, 2);
    end
    chk("R6 irq pending", wd_irq, 1);
    chk("R6 no reset request", wd_rst_req, 0);
    wr_reg(OFF_CLR, 16'h0000);
    @(posedge clk); #1;
    chk("R8 clear drops irq", wd_irq, 0);
    rd_reg(OFF_VAL, rd); chk("R8 clear reloads count", rd, 16'h0007);

    // ---- R9 only reset unlocks ----
    do_reset();
    rd_reg(OFF_STAT, rd); chk("R9 reset clears lock", rd[4], 0);
    wr_reg(OFF_LOAD, 16'h0033);
    rd_reg(OFF_LOAD, rd); chk("R9 writable after reset", rd, 16'h0033);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule